// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block is a first-level address translation cache. It holds a small set of virtual-to-physical page mappings and answers each lookup one cycle after the request. Every stored mapping is compared with the request at the same time. Each mapping carries its own page size, so one entry can cover a 4 KiB, 16 KiB, 64 KiB, 2 MiB or 32 MiB region. The address bits below the page boundary pass straight through to the 40-bit physical address.

Each match is qualified by two context tags: an address-space tag and a virtual-machine tag. A mapping flagged as global ignores the address-space tag. The virtual-machine tag must always agree. Because of this, switching processes or guests needs no flush. When a lookup misses, the block raises a miss request toward a unified second-level buffer, and the requester waits for the refill. The refill port writes a new mapping. Invalidate commands can clear all entries, or only the entries selected by address-space tag, by virtual-machine tag, or by address.

Top module: `xlat_tlb_l1`

## Requirements
- R1: After reset, no entry is valid. `rsp_valid`, `rsp_hit`, `miss_req`, `rsp_pa` and `rsp_attr` are 0, and the first lookup misses.
- R2: A request with `lk_valid` high produces exactly one response with `rsp_valid` high on the next clock edge. No response appears without a request.
- R3: The page-size code is 0=4 KiB, 1=16 KiB, 2=64 KiB, 3=2 MiB, 4=32 MiB, which gives 12, 14, 16, 21 or 25 offset bits. On a hit, `rsp_pa` takes the entry's physical bits above the offset and the request's address bits below it. The tag compare ignores the virtual bits below the offset.
- R4: An entry with its global flag set matches any `lk_asid`. A non-global entry matches only when its stored address-space tag equals `lk_asid`.
- R5: An entry matches only when its stored virtual-machine tag equals `lk_vmid`, whether or not it is global.
- R6: On a miss, `miss_req` is high together with the response, with `rsp_hit`, `rsp_pa` and `rsp_attr` at 0. `miss_va`, `miss_asid` and `miss_vmid` repeat the request. On a hit, `miss_req` is low.
- R7: A refill writes the lowest-index invalid entry. When every entry is valid, it writes the entry at a round-robin pointer instead. The pointer starts at 0 after reset, advances by one (wrapping) only on such a replacement, and the written entry is valid from the next cycle.
- R8: When several entries match one request, the response uses the lowest-index matching entry.
- R9: Invalidate with `inv_kind`=0 clears every entry.
- R10: Invalidate with `inv_kind`=1 clears non-global entries whose address-space tag equals `inv_asid`. Global entries are kept.
- R11: Invalidate with `inv_kind`=2 clears every entry whose virtual-machine tag equals `inv_vmid`.
- R12: Invalidate with `inv_kind`=3 clears each entry whose virtual page equals `inv_vpn` under that entry's own page-size mask, in any context. Other entries are kept.
- R13: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_vmid | input | VMID_W | Lookup virtual-machine tag |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | VA_W-12 | Refill virtual page (4 KiB units, size-aligned) |
| rf_ppn | input | PA_W-12 | Refill physical page (4 KiB units, size-aligned) |
| rf_size | input | 3 | Refill page-size code |
| rf_global | input | 1 | Refill global flag |
| rf_asid | input | ASID_W | Refill address-space tag |
| rf_vmid | input | VMID_W | Refill virtual-machine tag |
| rf_attr | input | ATTR_W | Refill attribute bits |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_kind | input | 2 | Invalidate selector: 0 all, 1 tag, 2 machine, 3 address |
| inv_asid | input | ASID_W | Address-space tag for selector 1 |
| inv_vmid | input | VMID_W | Virtual-machine tag for selector 2 |
| inv_vpn | input | VA_W-12 | Virtual page for selector 3 |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Response hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_attr | output | ATTR_W | Attributes of the hit entry |
| miss_req | output | 1 | Miss request to the next level |
| miss_va | output | VA_W | Missed virtual address |
| miss_asid | output | ASID_W | Missed address-space tag |
| miss_vmid | output | VMID_W | Missed virtual-machine tag |

## Verification
The embedded properties check several rules on every cycle. Each request gets exactly one response on the next edge. A hit and a miss request never appear together. A refilled entry is valid on the following cycle, and the victim is always a free slot while one exists. A full invalidate leaves nothing valid. Other behaviour can only be shown by bench scenarios with chosen addresses and tags:
- the address formed under each of the five page sizes,
- the context qualification by address-space and virtual-machine tag,
- lowest-index priority on overlapping entries,
- the pre-refill view on a same-cycle lookup,
- each invalidate selector,
- the order of round-robin replacement once the buffer is full.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_BASE = 12;

  typedef enum logic [2:0] {
    PG_4K  = 3'd0,
    PG_16K = 3'd1,
    PG_64K = 3'd2,
    PG_2M  = 3'd3,
    PG_32M = 3'd4
  } pg_size_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_VMID = 2'd2,
    INV_ADDR = 2'd3
  } inv_kind_e;

  // number of virtual page bits (in 4 KiB units) ignored for a page size
  function automatic logic [4:0] pg_extra_bits(input logic [2:0] sz);
    case (pg_size_e'(sz))
      PG_16K:  return 5'd2;
      PG_64K:  return 5'd4;
      PG_2M:   return 5'd9;
      PG_32M:  return 5'd13;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_lowest_pick.sv
module tlb_lowest_pick #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
  import tlb_pkg::*;
#(
  parameter int N      = 48,
  parameter int VPN_W  = 36,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn    [N],
  input  logic [2:0]        ent_size   [N],
  input  logic [N-1:0]      ent_global,
  input  logic [ASID_W-1:0] ent_asid   [N],
  input  logic [VMID_W-1:0] ent_vmid   [N],
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VMID_W-1:0] req_vmid,
  input  logic              use_ctx,
  output logic [N-1:0]      match
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [VPN_W-1:0] care;
    logic             tag_eq;
    logic             ctx_ok;
    always_comb begin
      care   = ~((VPN_W'(1) << pg_extra_bits(ent_size[g])) - VPN_W'(1));
      tag_eq = ((ent_vpn[g] ^ req_vpn) & care) == '0;
      ctx_ok = (ent_vmid[g] == req_vmid) &&
               (ent_global[g] || (ent_asid[g] == req_asid));
    end
    assign match[g] = ent_valid[g] && tag_eq && (!use_ctx || ctx_ok);
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     ent_valid,
  input  logic             fill,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  tlb_lowest_pick #(.N(N), .IDX_W(IDX_W)) u_free (
    .vec   (~ent_valid),
    .found (free_any),
    .idx   (free_idx)
  );

  assign victim = free_any ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill && !free_any) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (rst)
    free_any |-> !ent_valid[victim]);
endmodule

// File: rtl/xlat_tlb_l1.sv
module xlat_tlb_l1
  import tlb_pkg::*;
#(
  parameter int N      = 48,
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16,
  parameter int ATTR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic [ASID_W-1:0]     lk_asid,
  input  logic [VMID_W-1:0]     lk_vmid,
  input  logic                  rf_valid,
  input  logic [VA_W-13:0]      rf_vpn,
  input  logic [PA_W-13:0]      rf_ppn,
  input  logic [2:0]            rf_size,
  input  logic                  rf_global,
  input  logic [ASID_W-1:0]     rf_asid,
  input  logic [VMID_W-1:0]     rf_vmid,
  input  logic [ATTR_W-1:0]     rf_attr,
  input  logic                  inv_valid,
  input  logic [1:0]            inv_kind,
  input  logic [ASID_W-1:0]     inv_asid,
  input  logic [VMID_W-1:0]     inv_vmid,
  input  logic [VA_W-13:0]      inv_vpn,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [PA_W-1:0]       rsp_pa,
  output logic [ATTR_W-1:0]     rsp_attr,
  output logic                  miss_req,
  output logic [VA_W-1:0]       miss_va,
  output logic [ASID_W-1:0]     miss_asid,
  output logic [VMID_W-1:0]     miss_vmid
);
  localparam int VPN_W = VA_W - PAGE_BASE;
  localparam int PPN_W = PA_W - PAGE_BASE;
  localparam int IDX_W = $clog2(N);

  // entry storage
  logic [N-1:0]      valid_q, valid_d;
  logic [VPN_W-1:0]  e_vpn  [N];
  logic [PPN_W-1:0]  e_ppn  [N];
  logic [2:0]        e_size [N];
  logic [N-1:0]      e_glob;
  logic [ASID_W-1:0] e_asid [N];
  logic [VMID_W-1:0] e_vmid [N];
  logic [ATTR_W-1:0] e_attr [N];

  logic [N-1:0]      lk_match, inv_match;
  logic              lk_any;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  victim;
  logic [PA_W-1:0]   lo_mask, pa_c;

  // lookup compare (context qualified)
  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_lk_cam (
    .ent_valid (valid_q), .ent_vpn (e_vpn), .ent_size (e_size), .ent_global (e_glob),
    .ent_asid (e_asid), .ent_vmid (e_vmid),
    .req_vpn (lk_va[VA_W-1:PAGE_BASE]), .req_asid (lk_asid), .req_vmid (lk_vmid),
    .use_ctx (1'b1), .match (lk_match)
  );

  // address invalidate compare (context ignored)
  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_inv_cam (
    .ent_valid (valid_q), .ent_vpn (e_vpn), .ent_size (e_size), .ent_global (e_glob),
    .ent_asid (e_asid), .ent_vmid (e_vmid),
    .req_vpn (inv_vpn), .req_asid (inv_asid), .req_vmid (inv_vmid),
    .use_ctx (1'b0), .match (inv_match)
  );

  tlb_lowest_pick #(.N(N), .IDX_W(IDX_W)) u_hit_pick (
    .vec (lk_match), .found (lk_any), .idx (lk_idx)
  );

  tlb_victim_sel #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk (clk), .rst (rst), .ent_valid (valid_q), .fill (rf_valid), .victim (victim)
  );

  // physical address formation
  always_comb begin
    lo_mask = (PA_W'(1) << (PAGE_BASE + int'(pg_extra_bits(e_size[lk_idx])))) - PA_W'(1);
    pa_c    = ({e_ppn[lk_idx], {PAGE_BASE{1'b0}}} & ~lo_mask) | (lk_va[PA_W-1:0] & lo_mask);
  end

  // next valid vector: invalidate on old state, then refill
  always_comb begin
    valid_d = valid_q;
    if (inv_valid) begin
      for (int i = 0; i < N; i++) begin
        case (inv_kind_e'(inv_kind))
          INV_ALL:  valid_d[i] = 1'b0;
          INV_ASID: if (!e_glob[i] && e_asid[i] == inv_asid) valid_d[i] = 1'b0;
          INV_VMID: if (e_vmid[i] == inv_vmid) valid_d[i] = 1'b0;
          default:  if (inv_match[i]) valid_d[i] = 1'b0;
        endcase
      end
    end
    if (rf_valid) valid_d[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (rf_valid) begin
      e_vpn[victim]  <= rf_vpn;
      e_ppn[victim]  <= rf_ppn;
      e_size[victim] <= rf_size;
      e_glob[victim] <= rf_global;
      e_asid[victim] <= rf_asid;
      e_vmid[victim] <= rf_vmid;
      e_attr[victim] <= rf_attr;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
      miss_req  <= 1'b0;
      miss_va   <= '0;
      miss_asid <= '0;
      miss_vmid <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any;
      rsp_pa    <= (lk_valid && lk_any) ? pa_c : '0;
      rsp_attr  <= (lk_valid && lk_any) ? e_attr[lk_idx] : '0;
      miss_req  <= lk_valid && !lk_any;
      if (lk_valid) begin
        miss_va   <= lk_va;
        miss_asid <= lk_asid;
        miss_vmid <= lk_vmid;
      end
    end
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid && !miss_req);
  // R6
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> !miss_req);
  // R7
  refill_set_chk: assert property (@(posedge clk) disable iff (rst)
    rf_valid |=> valid_q[$past(victim)]);
  // R9
  inv_all_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid && inv_kind == INV_ALL && !rf_valid |=> valid_q == '0);
endmodule

// File: tb/xlat_tlb_l1_tb.sv
`timescale 1ns/1ps
module xlat_tlb_l1_tb;
  localparam int VA_W = 48, PA_W = 40, ASID_W = 16, VMID_W = 16, ATTR_W = 8, N = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              lk_valid = 0;
  logic [VA_W-1:0]   lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [VMID_W-1:0] lk_vmid = '0;
  logic              rf_valid = 0;
  logic [VA_W-13:0]  rf_vpn = '0;
  logic [PA_W-13:0]  rf_ppn = '0;
  logic [2:0]        rf_size = '0;
  logic              rf_global = 0;
  logic [ASID_W-1:0] rf_asid = '0;
  logic [VMID_W-1:0] rf_vmid = '0;
  logic [ATTR_W-1:0] rf_attr = '0;
  logic              inv_valid = 0;
  logic [1:0]        inv_kind = '0;
  logic [ASID_W-1:0] inv_asid = '0;
  logic [VMID_W-1:0] inv_vmid = '0;
  logic [VA_W-13:0]  inv_vpn = '0;
  logic              rsp_valid, rsp_hit, miss_req;
  logic [PA_W-1:0]   rsp_pa;
  logic [ATTR_W-1:0] rsp_attr;
  logic [VA_W-1:0]   miss_va;
  logic [ASID_W-1:0] miss_asid;
  logic [VMID_W-1:0] miss_vmid;

  xlat_tlb_l1 u_dut (.*);

  typedef struct {
    logic              hit;
    logic [PA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
    logic [VA_W-1:0]   va;
    string             tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  function automatic logic [PA_W-1:0] xpa(input logic [PA_W-1:0] base,
                                           input logic [VA_W-1:0] va, input logic [2:0] sz);
    int off;
    logic [PA_W-1:0] m;
    case (sz)
      3'd1: off = 14;
      3'd2: off = 16;
      3'd3: off = 21;
      3'd4: off = 25;
      default: off = 12;
    endcase
    m = (PA_W'(1) << off) - PA_W'(1);
    return (base & ~m) | (va[PA_W-1:0] & m);
  endfunction

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response: got rsp_valid=1 expected none");
      end else begin
        mon_e = sb_q.pop_front();
        if (rsp_hit !== mon_e.hit || rsp_pa !== mon_e.pa || rsp_attr !== mon_e.attr ||
            miss_req !== !mon_e.hit || (!mon_e.hit && miss_va !== mon_e.va)) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b pa=%h attr=%h miss=%0b mva=%h expected hit=%0b pa=%h attr=%h miss=%0b mva=%h",
                   mon_e.tag, rsp_hit, rsp_pa, rsp_attr, miss_req, miss_va,
                   mon_e.hit, mon_e.pa, mon_e.attr, !mon_e.hit, mon_e.va);
        end
      end
    end
  end

  task automatic lookup(input logic [VA_W-1:0] va, input logic [15:0] asid,
                        input logic [15:0] vmid, input logic hit,
                        input logic [PA_W-1:0] base, input logic [2:0] sz,
                        input logic [7:0] attr, input string tag);
    exp_t x;
    x.hit  = hit;
    x.pa   = hit ? xpa(base, va, sz) : '0;
    x.attr = hit ? attr : '0;
    x.va   = va;
    x.tag  = tag;
    sb_q.push_back(x);
    lk_valid = 1; lk_va = va; lk_asid = asid; lk_vmid = vmid;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic refill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                        input logic [2:0] sz, input logic glob, input logic [15:0] asid,
                        input logic [15:0] vmid, input logic [7:0] attr);
    rf_valid = 1; rf_vpn = va[VA_W-1:12]; rf_ppn = pa[PA_W-1:12]; rf_size = sz;
    rf_global = glob; rf_asid = asid; rf_vmid = vmid; rf_attr = attr;
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic inval(input logic [1:0] kind, input logic [15:0] asid,
                       input logic [15:0] vmid, input logic [VA_W-1:0] va);
    inv_valid = 1; inv_kind = kind; inv_asid = asid; inv_vmid = vmid; inv_vpn = va[VA_W-1:12];
    @(negedge clk);
    inv_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got no completion expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    n_checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || miss_req !== 0 || rsp_pa !== '0 || rsp_attr !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got v=%0b h=%0b m=%0b pa=%h expected all zero",
               rsp_valid, rsp_hit, miss_req, rsp_pa);
    end
    lookup(48'h0000_1234_5abc, 5, 2, 0, 0, 0, 0, "R1 empty lookup misses");

    // entries A..F at indices 0..5
    refill(48'h0000_1234_5000, 40'h12_3456_7000, 3'd0, 0, 5, 2, 8'h11);  // A
    refill(48'h0000_4000_0000, 40'h80_0020_0000, 3'd3, 1, 7, 2, 8'h22);  // B
    refill(48'h0000_0800_c000, 40'h00_0abc_4000, 3'd1, 0, 5, 2, 8'h33);  // C
    refill(48'h0000_7777_0000, 40'h01_2340_0000, 3'd2, 1, 5, 2, 8'h44);  // D
    refill(48'h0002_0000_0000, 40'h40_0200_0000, 3'd4, 0, 8, 2, 8'h55);  // E
    refill(48'h0002_0012_3000, 40'h99_9999_9000, 3'd0, 0, 8, 2, 8'h66);  // F

    lookup(48'h0000_1234_5abc, 5, 2, 1, 40'h12_3456_7000, 3'd0, 8'h11, "R3 4K page hit");
    lookup(48'h0000_0800_dff0, 5, 2, 1, 40'h00_0abc_4000, 3'd1, 8'h33, "R3 16K page hit");
    lookup(48'h0000_0801_0000, 5, 2, 0, 0, 0, 0, "R3 16K page boundary miss");
    lookup(48'h0000_7777_fffc, 3, 2, 1, 40'h01_2340_0000, 3'd2, 8'h44, "R3 64K page hit");
    lookup(48'h0000_4012_3456, 99, 2, 1, 40'h80_0020_0000, 3'd3, 8'h22, "R4 global 2M any tag");
    lookup(48'h0002_01ab_cdef, 8, 2, 1, 40'h40_0200_0000, 3'd4, 8'h55, "R3 32M page hit");
    lookup(48'h0000_1234_5000, 6, 2, 0, 0, 0, 0, "R4 tag mismatch misses");
    lookup(48'h0000_1234_5000, 5, 3, 0, 0, 0, 0, "R5 machine mismatch misses");
    lookup(48'h0000_4012_3456, 7, 3, 0, 0, 0, 0, "R5 global still needs machine tag");
    lookup(48'h0002_0012_3456, 8, 2, 1, 40'h40_0200_0000, 3'd4, 8'h55, "R8 lowest index wins");
    lookup(48'h0000_0000_0000, 8, 2, 0, 0, 0, 0, "R6 miss request fields");

    // R13: same-cycle refill and lookup of G
    begin
      exp_t x;
      x.hit = 0; x.pa = '0; x.attr = '0; x.va = 48'h0000_00aa_a123; x.tag = "R13 pre-refill view";
      sb_q.push_back(x);
      lk_valid = 1; lk_va = 48'h0000_00aa_a123; lk_asid = 1; lk_vmid = 4;
      rf_valid = 1; rf_vpn = 36'h0000_00aaa; rf_ppn = 28'h000_bbbb; rf_size = 3'd0;
      rf_global = 0; rf_asid = 1; rf_vmid = 4; rf_attr = 8'h77;
      @(negedge clk);
      lk_valid = 0; rf_valid = 0;
    end
    lookup(48'h0000_00aa_a123, 1, 4, 1, 40'h00_0bbb_b000, 3'd0, 8'h77, "R13 hit after refill");

    // R12 invalidate by address under 32M mask clears E only
    inval(2'd3, 0, 0, 48'h0002_0100_0000);
    lookup(48'h0002_0012_3456, 8, 2, 1, 40'h99_9999_9000, 3'd0, 8'h66, "R12 F kept, E gone");
    lookup(48'h0002_0150_0000, 8, 2, 0, 0, 0, 0, "R12 masked page cleared");
    lookup(48'h0000_1234_5abc, 5, 2, 1, 40'h12_3456_7000, 3'd0, 8'h11, "R12 other entry kept");

    // R10 invalidate by tag 5
    inval(2'd1, 5, 0, 0);
    lookup(48'h0000_1234_5abc, 5, 2, 0, 0, 0, 0, "R10 non-global A cleared");
    lookup(48'h0000_0800_dff0, 5, 2, 0, 0, 0, 0, "R10 non-global C cleared");
    lookup(48'h0000_7777_fffc, 3, 2, 1, 40'h01_2340_0000, 3'd2, 8'h44, "R10 global D kept");
    lookup(48'h0002_0012_3456, 8, 2, 1, 40'h99_9999_9000, 3'd0, 8'h66, "R10 other tag kept");

    // R11 invalidate by machine 2
    inval(2'd2, 0, 2, 0);
    lookup(48'h0000_4012_3456, 99, 2, 0, 0, 0, 0, "R11 global B cleared");
    lookup(48'h0002_0012_3456, 8, 2, 0, 0, 0, 0, "R11 F cleared");
    lookup(48'h0000_00aa_a123, 1, 4, 1, 40'h00_0bbb_b000, 3'd0, 8'h77, "R11 other machine kept");

    // R9 invalidate all
    inval(2'd0, 0, 0, 0);
    lookup(48'h0000_00aa_a123, 1, 4, 0, 0, 0, 0, "R9 all cleared");

    // R7 fill all entries, then replacement order
    for (int i = 0; i < N; i++)
      refill(48'h0010_0000_0000 + (48'(i) << 12), 40'h00_5000_0000 + (40'(i) << 12),
             3'd0, 0, 1, 1, 8'(i));
    lookup(48'h0010_0000_0010, 1, 1, 1, 40'h00_5000_0000, 3'd0, 8'd0, "R7 first filled");
    lookup(48'h0010_0002_f010, 1, 1, 1, 40'h00_5002_f000, 3'd0, 8'd47, "R7 last filled");
    refill(48'h0020_0000_0000, 40'h00_6000_0000, 3'd0, 0, 1, 1, 8'ha0);
    lookup(48'h0010_0000_0010, 1, 1, 0, 0, 0, 0, "R7 round-robin replaced index 0");
    lookup(48'h0020_0000_0004, 1, 1, 1, 40'h00_6000_0000, 3'd0, 8'ha0, "R7 new entry hits");
    lookup(48'h0010_0000_1010, 1, 1, 1, 40'h00_5000_1000, 3'd0, 8'd1, "R7 index 1 kept");
    refill(48'h0020_0000_1000, 40'h00_6000_1000, 3'd0, 0, 1, 1, 8'ha1);
    lookup(48'h0010_0000_1010, 1, 1, 0, 0, 0, 0, "R7 pointer advanced to index 1");
    lookup(48'h0010_0000_2010, 1, 1, 1, 40'h00_5000_2000, 3'd0, 8'd2, "R7 index 2 kept");
    inval(2'd3, 0, 0, 48'h0010_0000_a000);
    refill(48'h0020_0000_2000, 40'h00_6000_2000, 3'd0, 0, 1, 1, 8'ha2);
    lookup(48'h0010_0000_2010, 1, 1, 1, 40'h00_5000_2000, 3'd0, 8'd2, "R7 free slot preferred");
    lookup(48'h0020_0000_2008, 1, 1, 1, 40'h00_6000_2000, 3'd0, 8'ha2, "R7 free slot written");
    lookup(48'h0010_0000_a010, 1, 1, 0, 0, 0, 0, "R12 single page cleared");

    repeat (3) @(negedge clk);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses: got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule